// File: doc/BRIEF.md
# Predicated Four-Field Structure Load Sequencer

This block loads a vector's worth of four-field structures from contiguous memory and splits them across four destination vector registers. Each structure holds four 64-bit words. Word `f` of element `e` goes into element slot `e` of destination `f`. A start pulse supplies a 64-bit base address, a signed 4-bit displacement counted in whole four-vector groups, a predicate with one bit per element, and the index of the first destination register.

The sequencer walks the structures in memory order. It issues one 64-bit read at a time over a valid/ready request port and waits for each response before it moves on. Elements whose predicate bit is clear are skipped without any memory traffic, and they read back as zero in all four destinations.

Once the last element is handled, the four assembled vectors are written to the register file on consecutive cycles. The register indices wrap modulo 32. A one-cycle completion pulse follows the last write.

Top module: `s4l_struct_loader`

## Requirements
- R1: The first structure's address is `base_i + sext(imm_i) * NELEM * 32` modulo 2^64, where `NELEM = VLEN_BITS/64` and `imm_i` is two's complement in the range -8..7.
- R2: Word `f` (0..3) of element `e` is read from `start + 32*e + 8*f`. Reads are issued with `e` as the outer order and `f` as the inner order, skipped elements included in the address arithmetic.
- R3: An element whose bit `pred_i[e]` is 0 causes no memory read, and bits `[64e+63:64e]` are zero in all four destination vectors.
- R4: For an active element, the response data for word `f` lands in bits `[64e+63:64e]` of destination `f`.
- R5: After all reads complete, destination `f` is written with `rf_we_o` high and `rf_idx_o = (dst_i + f) mod 32`, for `f = 0,1,2,3` on four consecutive cycles. No write overlaps a pending read.
- R6: `mem_req_o` and `mem_addr_o` stay stable until `mem_gnt_i` accepts the request. No new request is raised until `mem_rvalid_i` returns the data of the previous one.
- R7: `done_o` is high for exactly one cycle, the cycle after the fourth register write. `busy_o` is low in the following cycle.
- R8: `start_i` while `busy_o` is high has no effect on the addresses, data or indices of the load in progress.
- R9: With every predicate bit clear, four all-zero registers are written and no memory read is issued.
- R10: During reset `busy_o`, `mem_req_o`, `rf_we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | 64 | Base byte address |
| imm_i | input | 4 | Signed group displacement |
| pred_i | input | VLEN_BITS/64 | Per-element predicate |
| dst_i | input | 5 | First destination register index |
| busy_o | output | 1 | Load in progress |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 64 | Read byte address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | 5 | Register file write index |
| rf_data_o | output | VLEN_BITS | Register file write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `VLEN_BITS = 256`, which gives four elements per vector. At that size all sixteen predicate patterns can be swept, each combined with several displacements across the full signed range, destination indices near 31 that force the wrap, and a base near zero so that negative displacements wrap the address. The memory model stalls grants on a rotating pattern and returns data derived from the address. This makes every misplaced word, wrong address or skipped zeroing show up as a mismatch. Some runs also pulse `start_i` with different operands in the middle of a load.

// File: rtl/s4l_pkg.sv
package s4l_pkg;
  localparam int FIELDS     = 4;
  localparam int FLD_W      = 2;
  localparam int REG_IDX_W  = 5;
  localparam int WORD_W     = 64;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ADDR_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_DONE
  } state_e;
endpackage

// File: rtl/s4l_addr_gen.sv
module s4l_addr_gen
  import s4l_pkg::*;
#(
  parameter int NELEM = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [3:0]        imm_i,
  output logic [ADDR_W-1:0] start_o
);
  localparam logic [ADDR_W-1:0] GROUP_BYTES = ADDR_W'(NELEM * FIELDS * WORD_BYTES);

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] disp;

  assign imm_ext = {{(ADDR_W-4){imm_i[3]}}, imm_i};
  // modular product equals the signed displacement
  assign disp    = imm_ext * GROUP_BYTES;
  assign start_o = base_i + disp;
endmodule

// File: rtl/s4l_field_buf.sv
module s4l_field_buf
  import s4l_pkg::*;
#(
  parameter int NELEM  = 4,
  parameter int EIDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    we_i,
  input  logic [EIDX_W-1:0]       slot_i,
  input  logic [WORD_W-1:0]       data_i,
  output logic [NELEM*WORD_W-1:0] vec_o
);
  for (genvar g = 0; g < NELEM; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q <= '0;
      else if (clr_i)                              slot_q <= '0;
      else if (we_i && slot_i == EIDX_W'(g))       slot_q <= data_i;
    end
    assign vec_o[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/s4l_ctrl.sv
module s4l_ctrl
  import s4l_pkg::*;
#(
  parameter int NELEM  = 4,
  parameter int EIDX_W = 2,
  parameter int ECNT_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NELEM-1:0]     pred_i,
  input  logic [REG_IDX_W-1:0] dst_i,
  input  logic [ADDR_W-1:0]    start_addr_i,
  output logic                 busy_o,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_gnt_i,
  input  logic                 mem_rvalid_i,
  output logic                 buf_clr_o,
  output logic [FIELDS-1:0]    buf_we_o,
  output logic [EIDX_W-1:0]    buf_slot_o,
  output logic [FLD_W-1:0]     wb_sel_o,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_idx_o,
  output logic                 done_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP   = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STRUCT_STEP = ADDR_W'(FIELDS * WORD_BYTES);
  localparam logic [ECNT_W-1:0] ELEM_END    = ECNT_W'(NELEM);
  localparam logic [FLD_W-1:0]  FLD_LAST    = FLD_W'(FIELDS - 1);

  state_e               state_q, state_d;
  logic [NELEM-1:0]     pred_q;
  logic [REG_IDX_W-1:0] dst_q;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [ECNT_W-1:0]    elem_q, elem_d;
  logic [FLD_W-1:0]     fld_q, fld_d;
  logic [FLD_W-1:0]     wb_q, wb_d;
  logic                 take;

  assign take = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    elem_d  = elem_q;
    fld_d   = fld_q;
    wb_d    = wb_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SCAN;
        addr_d  = start_addr_i;
        elem_d  = '0;
        fld_d   = '0;
      end
      ST_SCAN: begin
        if (elem_q == ELEM_END) begin
          state_d = ST_WB;
          wb_d    = '0;
        end else if (pred_q[elem_q[EIDX_W-1:0]]) begin
          state_d = ST_REQ;
        end else begin
          // inactive: skip whole structure, keep address in step
          addr_d = addr_q + STRUCT_STEP;
          elem_d = elem_q + 1'b1;
        end
      end
      ST_REQ: if (mem_gnt_i) state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) begin
        addr_d = addr_q + WORD_STEP;
        if (fld_q == FLD_LAST) begin
          fld_d   = '0;
          elem_d  = elem_q + 1'b1;
          state_d = ST_SCAN;
        end else begin
          fld_d   = fld_q + 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_WB: begin
        wb_d = wb_q + 1'b1;
        if (wb_q == FLD_LAST) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pred_q  <= '0;
      dst_q   <= '0;
      addr_q  <= '0;
      elem_q  <= '0;
      fld_q   <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      elem_q  <= elem_d;
      fld_q   <= fld_d;
      wb_q    <= wb_d;
      if (take) begin
        pred_q <= pred_i;
        dst_q  <= dst_i;
      end
    end
  end

  always_comb begin
    buf_we_o = '0;
    if (state_q == ST_WAIT && mem_rvalid_i) buf_we_o[fld_q] = 1'b1;
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = addr_q;
  assign buf_clr_o  = take;
  assign buf_slot_o = elem_q[EIDX_W-1:0];
  assign wb_sel_o   = wb_q;
  assign rf_we_o    = (state_q == ST_WB);
  assign rf_idx_o   = dst_q + REG_IDX_W'(wb_q);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/s4l_struct_loader.sv
module s4l_struct_loader
  import s4l_pkg::*;
#(
  parameter int VLEN_BITS = 256,
  localparam int NELEM    = VLEN_BITS / WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [3:0]           imm_i,
  input  logic [NELEM-1:0]     pred_i,
  input  logic [REG_IDX_W-1:0] dst_i,
  output logic                 busy_o,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_gnt_i,
  input  logic                 mem_rvalid_i,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_idx_o,
  output logic [VLEN_BITS-1:0] rf_data_o,
  output logic                 done_o
);
  localparam int EIDX_W = (NELEM > 1) ? $clog2(NELEM) : 1;
  localparam int ECNT_W = $clog2(NELEM + 1);

  logic [ADDR_W-1:0]    start_addr;
  logic                 buf_clr;
  logic [FIELDS-1:0]    buf_we;
  logic [EIDX_W-1:0]    buf_slot;
  logic [FLD_W-1:0]     wb_sel;
  logic [VLEN_BITS-1:0] vecs [FIELDS];

  s4l_addr_gen #(.NELEM(NELEM)) u_addr (
    .base_i (base_i),
    .imm_i  (imm_i),
    .start_o(start_addr)
  );

  s4l_ctrl #(.NELEM(NELEM), .EIDX_W(EIDX_W), .ECNT_W(ECNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pred_i      (pred_i),
    .dst_i       (dst_i),
    .start_addr_i(start_addr),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .buf_clr_o   (buf_clr),
    .buf_we_o    (buf_we),
    .buf_slot_o  (buf_slot),
    .wb_sel_o    (wb_sel),
    .rf_we_o     (rf_we_o),
    .rf_idx_o    (rf_idx_o),
    .done_o      (done_o)
  );

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    s4l_field_buf #(.NELEM(NELEM), .EIDX_W(EIDX_W)) u_buf (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (buf_clr),
      .we_i  (buf_we[f]),
      .slot_i(buf_slot),
      .data_i(mem_rdata_i),
      .vec_o (vecs[f])
    );
  end

  assign rf_data_o = vecs[wb_sel];
endmodule

// File: rtl/s4l_struct_loader_chk.sv
module s4l_struct_loader_chk #(
  parameter int VLEN_BITS = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o,
  input logic        mem_gnt_i,
  input logic        mem_rvalid_i,
  input logic        rf_we_o,
  input logic [4:0]  rf_idx_o,
  input logic        done_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     outst_q <= 1'b0;
    else if (mem_req_o && mem_gnt_i) outst_q <= 1'b1;
    else if (mem_rvalid_i)           outst_q <= 1'b0;
  end

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  assert_single_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_o);

  assert_wb_after_reads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_req_o && !outst_q);

  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && $past(rf_we_o) |-> rf_idx_o == $past(rf_idx_o) + 5'd1);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rf_we_o) && !rf_we_o);

  assert_req_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind s4l_struct_loader s4l_struct_loader_chk #(.VLEN_BITS(VLEN_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i),
  .rf_we_o     (rf_we_o),
  .rf_idx_o    (rf_idx_o),
  .done_o      (done_o)
);

// File: tb/s4l_struct_loader_test.sv
module s4l_struct_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 256;
  localparam int NEL        = VLEN / 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [63:0]     base = '0;
  logic [3:0]      imm = '0;
  logic [NEL-1:0]  pred = '0;
  logic [4:0]      dst = '0;
  logic            busy, mem_req, mem_gnt, mem_rvalid, rf_we, done;
  logic [63:0]     mem_addr, mem_rdata;
  logic [4:0]      rf_idx;
  logic [VLEN-1:0] rf_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  s4l_struct_loader #(.VLEN_BITS(VLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .imm_i(imm),
    .pred_i(pred), .dst_i(dst), .busy_o(busy), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .rf_data_o(rf_data), .done_o(done)
  );

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5C3_0F96, ~a[31:0]};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // shared with responder and monitor
  logic [63:0]     exp_addr [64];
  int              exp_n = 0;
  int              rd_cnt = 0;
  int              wr_cnt = 0;
  int              done_cnt = 0;
  logic [4:0]      run_dst = '0;
  logic [VLEN-1:0] got_vec [32];

  // memory responder: rotating grant stall, response one cycle after grant
  initial begin
    bit          pend = 0;
    logic [63:0] pend_addr = '0;
    int          stall = 0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      stall++;
      mem_gnt    = 1'b0;
      mem_rvalid = 1'b0;
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(pend_addr);
        pend = 0;
      end else if (mem_req && (stall % 3 != 1)) begin
        mem_gnt   = 1'b1;
        pend      = 1;
        pend_addr = mem_addr;
        if (rd_cnt < exp_n)
          check(mem_addr == exp_addr[rd_cnt], (rd_cnt == 0) ? "R1 first address" : "R2 read order",
                VLEN'(mem_addr), VLEN'(exp_addr[rd_cnt]));
        else
          check(1'b0, "R3 extra read", VLEN'(mem_addr), '0);
        rd_cnt++;
      end
    end
  end

  // register file monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rf_we && rst_n) begin
        check(rf_idx == 5'(run_dst + 5'(wr_cnt)), "R5 write index order",
              VLEN'(rf_idx), VLEN'(5'(run_dst + 5'(wr_cnt))));
        got_vec[rf_idx] = rf_data;
        wr_cnt++;
      end
      if (done && rst_n) done_cnt++;
    end
  end

  task automatic run_case(input logic [NEL-1:0] p, input logic [3:0] im,
                          input logic [4:0] d, input logic [63:0] b, input bit inject);
    logic [63:0]     st;
    logic [VLEN-1:0] ev;
    int              waited;
    int              act_n;
    st = b + {{60{im[3]}}, im} * 64'(NEL * 32);
    exp_n = 0; act_n = 0;
    for (int e = 0; e < NEL; e++)
      if (p[e]) begin
        act_n++;
        for (int f = 0; f < 4; f++) begin
          exp_addr[exp_n] = st + 64'(32*e + 8*f);
          exp_n++;
        end
      end
    for (int r = 0; r < 32; r++) got_vec[r] = {VLEN{1'b1}};
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; run_dst = d;

    @(negedge clk);
    start = 1'b1; pred = p; imm = im; dst = d; base = b;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      // R8: start while busy with different operands
      repeat (2) @(negedge clk);
      start = 1'b1; pred = ~p; imm = im + 4'd3; dst = d + 5'd11; base = b ^ 64'hFFFF_0000;
      repeat (2) @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 800) begin
      @(negedge clk); #1;
      waited++;
    end
    if (done_cnt == 0) check(1'b0, "R7 watchdog: no done", '0, 1);
    @(negedge clk); #1;
    check(done_cnt == 1, "R7 single done pulse", VLEN'(done_cnt), 1);
    check(busy == 1'b0, "R7 idle after done", VLEN'(busy), 0);
    check(wr_cnt == 4, "R5 four writes", VLEN'(wr_cnt), 4);
    check(rd_cnt == 4*act_n, (p == '0) ? "R9 no reads" : "R3 read count",
          VLEN'(rd_cnt), VLEN'(4*act_n));
    for (int f = 0; f < 4; f++) begin
      ev = '0;
      for (int e = 0; e < NEL; e++)
        if (p[e]) ev[64*e +: 64] = mem_word(st + 64'(32*e + 8*f));
      check(got_vec[5'(d + 5'(f))] === ev,
            (p == '0) ? "R9 zero vector" : (inject ? "R8 data under busy start" : "R4 R3 vector"),
            got_vec[5'(d + 5'(f))], ev);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && mem_req == 0 && rf_we == 0 && done == 0, "R10 reset outputs",
          VLEN'({busy, mem_req, rf_we, done}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        logic [63:0] b;
        b = (k == 3) ? 64'h40 : 64'h1000_0000_0000_8000 + 64'(p * k * 64);
        run_case(NEL'(p), 4'((p + k*5) % 16), 5'((p*7 + k*9 + 28) % 32), b, k == 2);
        repeat (2) @(negedge clk);
      end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule